// File: doc/BRIEF.md
# Seven-Level Priority Interrupt Controller

This block arbitrates interrupt requests for a 36-bit processor across seven priority levels, numbered 1 (most urgent) to 7 (least urgent). Each level can be requested by I/O devices, by internal trap sources, by internal error sources, or by software. A global enable and per-level enables gate the hardware sources. The controller records which levels are in service and raises a request to the processor only when some pending level outranks every level in service.

When the processor accepts an interrupt it pulses a start input. The controller then presents a vector address for the winning level and marks that level as in service. Each level owns a pair of adjacent vector slots. The second slot of the pair is used when the level is already in service. A dismiss pulse retires the most urgent level in service. A status word packs the software requests, in-service bits and enables into one 36-bit value that can be read.

Top module: `pri_irq_ctrl`

## Requirements
- R1: The hardware request of a level is the OR of its device, trap and error request bits, and it counts only while that level's enable is set. Port bit i of every level vector is level i+1.
- R2: A level's effective request is its software request bit OR (its level enable AND its hardware request), so a software request is effective while its level enable is clear.
- R3: While a level k is in service (k being the most urgent in-service level), levels k through 7 are masked. With no level in service, nothing is masked.
- R4: `irq_pending` is 1 exactly when the global enable is set and at least one effective request is unmasked.
- R5: While `start_irq` is high and an effective request exists, `vec_addr` = octal 40 + 2*L + (1 if level L is in service, else 0), where L is the most urgent effective request, masked or not. Otherwise `vec_addr` is octal 60.
- R6: A start pulse with an effective request sets the in-service bit of level L and sets `intr_insn` on the next clock. A start pulse with no effective request changes nothing.
- R7: A dismiss pulse clears only the in-service bit of the most urgent level in service. It has no effect when no level is in service.
- R8: A `clr_intr_insn` pulse clears `intr_insn`. A start with an effective request in the same cycle takes precedence, and the flag is then set.
- R9: A `pi_reset` pulse clears the global enable, level enables, software requests, in-service bits and `intr_insn` on the next clock. It takes precedence over a control load and over a start in the same cycle.
- R10: `status_word` bits 35..25 are 0. Software request of level L is at bit 25-L. Bits 17..15 are 0. In-service of level L is at bit 15-L. The global enable is at bit 7. The level enable of level L is at bit 7-L.
- R11: A `ctl_load` pulse writes the global enable, level enables and software requests from the `ctl_*` inputs on the next clock.
- R12: While `rst_n` is low, all state is 0, `irq_pending` is 0 and `vec_addr` is octal 60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | 7 | Device request per level |
| trap_req | input | 7 | Internal trap request per level |
| err_req | input | 7 | Internal error request per level |
| ctl_load | input | 1 | Load enables and software requests |
| ctl_glb_en | input | 1 | Global enable value to load |
| ctl_lvl_en | input | 7 | Level enable values to load |
| ctl_sw_req | input | 7 | Software request values to load |
| pi_reset | input | 1 | Clear all interrupt state |
| start_irq | input | 1 | Processor accepts an interrupt |
| dismiss_irq | input | 1 | Retire the most urgent level in service |
| clr_intr_insn | input | 1 | Drop the interrupt-instruction flag |
| irq_pending | output | 1 | Interrupt request to the processor |
| vec_addr | output | 18 | Vector address |
| intr_insn | output | 1 | Interrupt-instruction flag |
| status_word | output | 36 | Packed status for reads |

## Verification
The bench builds the block with its default of seven levels and an 18-bit address. At that size every level-enable pattern can be swept against every device-request pattern, which is 16384 combinations. The bench also sweeps every trap, error and software request pattern, with the software sweep run with all level enables clear. For each of the seven in-service levels, all 128 request patterns are checked against the mask. This reaches every mask boundary and both vector slots of every level, including the case where a request arrives on the level that is already in service.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  localparam int unsigned PIC_LEVELS   = 7;
  localparam int unsigned PIC_ADDR_W   = 18;
  localparam int unsigned PIC_WORD_W   = 36;
  localparam int unsigned PIC_VEC_BASE = 'o40;
  localparam int unsigned PIC_UUO_VEC  = 'o60;

  // Two slots per level; the odd slot serves a level that is already active.
  function automatic int unsigned slot_addr(int unsigned base, int unsigned lvl_idx,
                                            logic busy);
    return base + 2 * (lvl_idx + 1) + (busy ? 1 : 0);
  endfunction
endpackage

// File: rtl/pic_prio_pick.sv
`timescale 1ns/1ps
// Finds the lowest-index (most urgent) set bit of a level vector.
module pic_prio_pick #(
  parameter int unsigned N     = 7,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     first_oh,
  output logic [IDX_W-1:0] first_idx,
  output logic             any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign seen[g+1]   = seen[g] | req[g];
    assign first_oh[g] = req[g] & ~seen[g];
  end

  assign any = seen[N];

  always_comb begin
    first_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (first_oh[i]) first_idx = first_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/pic_req_merge.sv
`timescale 1ns/1ps
// Combines request sources per level into effective requests.
module pic_req_merge #(
  parameter int unsigned N = 7
) (
  input  logic [N-1:0] dev_req,
  input  logic [N-1:0] trap_req,
  input  logic [N-1:0] err_req,
  input  logic [N-1:0] lvl_en,
  input  logic [N-1:0] sw_req,
  output logic [N-1:0] eff_req
);
  logic [N-1:0] hw_req;

  for (genvar g = 0; g < N; g++) begin : g_lvl
    assign hw_req[g]  = dev_req[g] | trap_req[g] | err_req[g];
    assign eff_req[g] = sw_req[g] | (lvl_en[g] & hw_req[g]);
  end
endmodule

// File: rtl/pic_level_state.sv
`timescale 1ns/1ps
// Holds enables, software requests, in-service bits and the interrupt flag.
module pic_level_state #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pi_reset,
  input  logic         ctl_load,
  input  logic         ctl_ge,
  input  logic [N-1:0] ctl_le,
  input  logic [N-1:0] ctl_sr,
  input  logic         start_go,
  input  logic [N-1:0] win_oh,
  input  logic         dismiss,
  input  logic [N-1:0] dis_oh,
  input  logic         clr_ii,
  output logic         ge_q,
  output logic [N-1:0] le_q,
  output logic [N-1:0] sr_q,
  output logic [N-1:0] ip_q,
  output logic         intr_q
);
  logic         ge_d, intr_d, upd_en;
  logic [N-1:0] le_d, sr_d, ip_d;

  assign upd_en = pi_reset | ctl_load | start_go | dismiss | clr_ii;

  always_comb begin
    ge_d   = ge_q;
    le_d   = le_q;
    sr_d   = sr_q;
    ip_d   = ip_q;
    intr_d = intr_q;
    if (pi_reset) begin
      ge_d   = 1'b0;
      le_d   = '0;
      sr_d   = '0;
      ip_d   = '0;
      intr_d = 1'b0;
    end else begin
      if (ctl_load) begin
        ge_d = ctl_ge;
        le_d = ctl_le;
        sr_d = ctl_sr;
      end
      ip_d = (ip_q & ~(dismiss ? dis_oh : '0)) | (start_go ? win_oh : '0);
      if (start_go)    intr_d = 1'b1;
      else if (clr_ii) intr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ge_q   <= 1'b0;
      le_q   <= '0;
      sr_q   <= '0;
      ip_q   <= '0;
      intr_q <= 1'b0;
    end else if (upd_en) begin
      ge_q   <= ge_d;
      le_q   <= le_d;
      sr_q   <= sr_d;
      ip_q   <= ip_d;
      intr_q <= intr_d;
    end
  end

  // R9
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pi_reset |=> (!ge_q && le_q == '0 && sr_q == '0 && ip_q == '0 && !intr_q));
  // R6
  start_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_go && !pi_reset) |=> intr_q);
  // R7
  dismiss_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dismiss && !start_go && !pi_reset && ip_q != '0)
      |=> ($countones(ip_q) + 1 == $countones($past(ip_q))));
  // R8
  clr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ii && !start_go && !pi_reset) |=> !intr_q);
  // R11
  load_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_load && !pi_reset)
      |=> (ge_q == $past(ctl_ge) && le_q == $past(ctl_le) && sr_q == $past(ctl_sr)));
endmodule

// File: rtl/pri_irq_ctrl.sv
`timescale 1ns/1ps
module pri_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned N        = PIC_LEVELS,
  parameter int unsigned ADDR_W   = PIC_ADDR_W,
  parameter int unsigned WORD_W   = PIC_WORD_W,
  parameter int unsigned VEC_BASE = PIC_VEC_BASE,
  parameter int unsigned UUO_VEC  = PIC_UUO_VEC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      dev_req,
  input  logic [N-1:0]      trap_req,
  input  logic [N-1:0]      err_req,
  input  logic              ctl_load,
  input  logic              ctl_glb_en,
  input  logic [N-1:0]      ctl_lvl_en,
  input  logic [N-1:0]      ctl_sw_req,
  input  logic              pi_reset,
  input  logic              start_irq,
  input  logic              dismiss_irq,
  input  logic              clr_intr_insn,
  output logic              irq_pending,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              intr_insn,
  output logic [WORD_W-1:0] status_word
);
  localparam int unsigned IDX_W  = (N > 1) ? $clog2(N) : 1;
  localparam int unsigned GE_BIT = N;
  localparam int unsigned IP_LSB = N + 1;
  localparam int unsigned SR_LSB = 2 * N + 4;

  logic             ge_q, intr_q, rq_any, ip_any, start_go;
  logic [N-1:0]     le_q, sr_q, ip_q, eff_req, win_oh, top_ip_oh, ip_mask;
  logic [IDX_W-1:0] win_idx, ip_idx;

  pic_req_merge #(.N(N)) u_merge (
    .dev_req (dev_req),
    .trap_req(trap_req),
    .err_req (err_req),
    .lvl_en  (le_q),
    .sw_req  (sr_q),
    .eff_req (eff_req)
  );

  pic_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick_req (
    .req      (eff_req),
    .first_oh (win_oh),
    .first_idx(win_idx),
    .any      (rq_any)
  );

  pic_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick_ip (
    .req      (ip_q),
    .first_oh (top_ip_oh),
    .first_idx(ip_idx),
    .any      (ip_any)
  );

  assign start_go = start_irq & rq_any;

  pic_level_state #(.N(N)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .pi_reset(pi_reset),
    .ctl_load(ctl_load),
    .ctl_ge  (ctl_glb_en),
    .ctl_le  (ctl_lvl_en),
    .ctl_sr  (ctl_sw_req),
    .start_go(start_go),
    .win_oh  (win_oh),
    .dismiss (dismiss_irq),
    .dis_oh  (top_ip_oh),
    .clr_ii  (clr_intr_insn),
    .ge_q    (ge_q),
    .le_q    (le_q),
    .sr_q    (sr_q),
    .ip_q    (ip_q),
    .intr_q  (intr_q)
  );

  // Mask covers the most urgent active level and everything below it.
  assign ip_mask[0] = ip_q[0];
  for (genvar g = 1; g < N; g++) begin : g_mask
    assign ip_mask[g] = ip_mask[g-1] | ip_q[g];
  end

  assign irq_pending = ge_q & ((eff_req & ~ip_mask) != '0);
  assign intr_insn   = intr_q;

  always_comb begin
    if (start_go) vec_addr = ADDR_W'(slot_addr(VEC_BASE, int'(win_idx), ip_q[win_idx]));
    else          vec_addr = ADDR_W'(UUO_VEC);
  end

  always_comb begin
    status_word = '0;
    status_word[GE_BIT] = ge_q;
    for (int i = 0; i < N; i++) begin
      status_word[N - 1 - i]          = le_q[i];
      status_word[IP_LSB + N - 1 - i] = ip_q[i];
      status_word[SR_LSB + N - 1 - i] = sr_q[i];
    end
  end

  // R4
  irq_needs_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> ge_q);
  // R3
  irq_outranks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && ip_any) |-> (win_idx < ip_idx));
  // R5
  win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh));
endmodule

// File: tb/pri_irq_ctrl_tb.sv
`timescale 1ns/1ps
module pri_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 7;
  localparam int WDOG       = 100000;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] dev_req, trap_req, err_req, ctl_lvl_en, ctl_sw_req;
  logic ctl_load, ctl_glb_en, pi_reset, start_irq, dismiss_irq, clr_intr_insn;
  logic irq_pending, intr_insn;
  logic [17:0] vec_addr;
  logic [35:0] status_word;

  int n_chk = 0;
  int n_bad = 0;

  logic         e_ge, e_intr;
  logic [N-1:0] e_le, e_sr, e_ip;

  always #(CLK_PERIOD/2) clk = ~clk;

  pri_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .trap_req(trap_req), .err_req(err_req),
    .ctl_load(ctl_load), .ctl_glb_en(ctl_glb_en), .ctl_lvl_en(ctl_lvl_en),
    .ctl_sw_req(ctl_sw_req), .pi_reset(pi_reset), .start_irq(start_irq),
    .dismiss_irq(dismiss_irq), .clr_intr_insn(clr_intr_insn), .irq_pending(irq_pending),
    .vec_addr(vec_addr), .intr_insn(intr_insn), .status_word(status_word)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_rq();
    return e_sr | (e_le & (dev_req | trap_req | err_req));
  endfunction

  function automatic int lowest(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic exp_irq();
    logic [N-1:0] rq = exp_rq();
    int k = lowest(e_ip);
    logic [N-1:0] unm = (k < 0) ? rq : (rq & N'((1 << k) - 1));
    return e_ge && (unm != 0);
  endfunction

  function automatic logic [35:0] exp_status();
    logic [35:0] s = '0;
    s[7] = e_ge;
    for (int l = 1; l <= N; l++) begin
      s[25 - l] = e_sr[l-1];
      s[15 - l] = e_ip[l-1];
      s[7 - l]  = e_le[l-1];
    end
    return s;
  endfunction

  function automatic logic [17:0] exp_vec();
    int w = lowest(exp_rq());
    if (w < 0) return 18'o60;
    return 18'(32 + 2 * (w + 1) + (e_ip[w] ? 1 : 0));
  endfunction

  task automatic check_state(string tag);
    chk({tag, " R4 irq"}, 64'(irq_pending), 64'(exp_irq()));
    chk({tag, " R10 status"}, 64'(status_word), 64'(exp_status()));
    chk({tag, " R6 flag"}, 64'(intr_insn), 64'(e_intr));
  endtask

  // Raise start away from the edge, look at the vector, drop it before the edge.
  task automatic probe_vec(string tag);
    start_irq = 1'b1;
    #1;
    chk({tag, " R5 vec"}, 64'(vec_addr), 64'(exp_vec()));
    start_irq = 1'b0;
    #1;
  endtask

  task automatic load_ctl(logic ge, logic [N-1:0] le, logic [N-1:0] sr);
    @(negedge clk);
    ctl_glb_en = ge; ctl_lvl_en = le; ctl_sw_req = sr; ctl_load = 1'b1;
    @(negedge clk);
    ctl_load = 1'b0;
    e_ge = ge; e_le = le; e_sr = sr;
    #1 check_state("R11 load");
  endtask

  task automatic do_start(string tag);
    int w;
    @(negedge clk);
    w = lowest(exp_rq());
    start_irq = 1'b1;
    @(negedge clk);
    start_irq = 1'b0;
    if (w >= 0) begin
      e_ip[w] = 1'b1;
      e_intr  = 1'b1;
    end
    #1 check_state(tag);
  endtask

  task automatic do_dismiss(string tag);
    int k;
    @(negedge clk);
    dismiss_irq = 1'b1;
    @(negedge clk);
    dismiss_irq = 1'b0;
    k = lowest(e_ip);
    if (k >= 0) e_ip[k] = 1'b0;
    #1 check_state(tag);
  endtask

  task automatic do_clr(string tag);
    @(negedge clk);
    clr_intr_insn = 1'b1;
    @(negedge clk);
    clr_intr_insn = 1'b0;
    e_intr = 1'b0;
    #1 check_state(tag);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    dev_req = '0; trap_req = '0; err_req = '0;
    ctl_load = 1'b0; ctl_glb_en = 1'b0; ctl_lvl_en = '0; ctl_sw_req = '0;
    pi_reset = 1'b0; start_irq = 1'b0; dismiss_irq = 1'b0; clr_intr_insn = 1'b0;
    e_ge = 1'b0; e_le = '0; e_sr = '0; e_ip = '0; e_intr = 1'b0;

    // R12 reset state
    repeat (3) @(negedge clk);
    check_state("R12 in reset");
    chk("R12 vec", 64'(vec_addr), 64'o60);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check_state("R12 after release");

    // R1 R2 R4 R5: every level enable against every device pattern
    for (int le = 0; le < 128; le++) begin
      load_ctl(1'b1, N'(le), '0);
      for (int d = 0; d < 128; d++) begin
        @(negedge clk);
        dev_req = N'(d);
        #1 chk("R1 dev sweep irq", 64'(irq_pending), 64'(exp_irq()));
        probe_vec("R1 dev sweep");
      end
    end
    dev_req = '0;

    // R1 trap and error sources
    load_ctl(1'b1, '1, '0);
    for (int t = 0; t < 128; t++) begin
      @(negedge clk);
      trap_req = N'(t);
      #1 chk("R1 trap irq", 64'(irq_pending), 64'(exp_irq()));
      probe_vec("R1 trap");
    end
    trap_req = '0;
    for (int t = 0; t < 128; t++) begin
      @(negedge clk);
      err_req = N'(t);
      #1 chk("R1 err irq", 64'(irq_pending), 64'(exp_irq()));
      probe_vec("R1 err");
    end
    err_req = '0;

    // R2 software requests with every level enable clear
    dev_req = '1;
    for (int s = 0; s < 128; s++) begin
      load_ctl(1'b1, '0, N'(s));
      probe_vec("R2 sw on disabled");
    end
    // R4 global enable clear blocks everything
    load_ctl(1'b0, '1, '1);
    chk("R4 ge off irq", 64'(irq_pending), 64'(0));
    dev_req = '0;

    // R3 R5 R6 R8: each level in service, sweep requests
    for (int k = 1; k <= N; k++) begin
      load_ctl(1'b1, '1, N'(1 << (k - 1)));
      probe_vec("R5 even slot");
      do_start("R6 start");
      load_ctl(1'b1, '1, '0);
      do_clr("R8 clear flag");
      for (int d = 0; d < 128; d++) begin
        @(negedge clk);
        dev_req = N'(d);
        #1 chk("R3 mask irq", 64'(irq_pending), 64'(exp_irq()));
        probe_vec("R3 R5 slot");
      end
      dev_req = '0;
      do_dismiss("R7 retire");
    end

    // R7 nesting: levels 5 then 2, retire in urgency order
    load_ctl(1'b1, '1, N'(1 << 4));
    do_start("R6 nest outer");
    load_ctl(1'b1, '1, N'(1 << 1));
    do_start("R6 nest inner");
    load_ctl(1'b1, '1, '0);
    do_dismiss("R7 nest inner out");
    do_dismiss("R7 nest outer out");
    do_dismiss("R7 empty dismiss");

    // R6 start with no request changes nothing
    do_clr("R8 pre");
    do_start("R6 empty start");

    // R8 start beats clear in the same cycle
    load_ctl(1'b1, '0, N'(1 << 6));
    @(negedge clk);
    start_irq = 1'b1; clr_intr_insn = 1'b1;
    @(negedge clk);
    start_irq = 1'b0; clr_intr_insn = 1'b0;
    e_ip[6] = 1'b1; e_intr = 1'b1;
    #1 check_state("R8 start wins");

    // R9 reset beats load and start
    @(negedge clk);
    pi_reset = 1'b1; ctl_load = 1'b1; ctl_glb_en = 1'b1; ctl_lvl_en = '1; ctl_sw_req = '1;
    start_irq = 1'b1;
    @(negedge clk);
    pi_reset = 1'b0; ctl_load = 1'b0; start_irq = 1'b0;
    e_ge = 1'b0; e_le = '0; e_sr = '0; e_ip = '0; e_intr = 1'b0;
    #1 check_state("R9 pi reset");
    chk("R9 status zero", 64'(status_word), 64'(0));

    finish_run();
  end
endmodule